// File: doc/BRIEF.md
# Prioritized Interrupt Request Latch

This block catches single-cycle request pulses from three interrupt sources and holds each one until the sequencer confirms that it has been serviced. The sources are numbered 3, 4 and 5. Sources 3 and 4 are timer interrupts and source 5 signals that keyboard data is ready. While an inhibit flag is high the block keeps collecting requests but does not tell the sequencer that anything is waiting. When the flag drops, any request collected during the inhibit shows up on the pending line straight away.

The sequencer fetches the jump-table address with a dedicated address-read pulse. On that pulse the block picks the lowest-numbered latched source. It registers that source's vector, `VEC_BASE + 4 * number`, and remembers which source it handed out. A later serviced acknowledge clears only that remembered source. Saving and restoring processor context is left to the sequencer.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst` is high at a clock edge, every latched request is cleared and the remembered source becomes invalid. After that edge, `pending_o` is 0 and `vector_o` is 0.
- R2: `irq_req_i` bit 0 stands for source 3, bit 1 for source 4 and bit 2 for source 5 (keyboard). A high bit at a clock edge latches that source. Once latched, the source stays latched through any number of idle cycles until an acknowledge clears it.
- R3: `pending_o` is high exactly when at least one source is latched and `inhibit_i` is low. The inhibit does not stop new requests from being latched.
- R4: On an `addr_rd_i` edge, the block picks the lowest-numbered latched source (3 before 4 before 5). From the next cycle, `vector_o` shows `VEC_BASE + 4*n` for that source n. With the default base of 0x010, these are 0x01C, 0x020 and 0x024.
- R5: A `svc_ack_i` edge clears only the source picked by the most recent address read. All other latched sources stay latched.
- R6: A request bit that is high in the same cycle as an acknowledge for that same source leaves the source latched.
- R7: An acknowledge consumes the remembered source. A second acknowledge with no address read in between changes nothing.
- R8: An address read that finds nothing latched leaves `vector_o` unchanged and invalidates the remembered source. A later acknowledge then clears nothing.
- R9: If an acknowledge and an address read arrive in the same cycle, the acknowledged source is cleared first. The new pick is made from the sources that remain.
- R10: `vector_o` changes only at edges where `addr_rd_i` is high (reset aside).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 3 | Request pulses: bit0 source 3, bit1 source 4, bit2 source 5 (keyboard) |
| inhibit_i | input | 1 | Blocks interrupt entry while high |
| addr_rd_i | input | 1 | Address-read pulse: pick a source and register its vector |
| svc_ack_i | input | 1 | Serviced acknowledge for the last source handed out |
| pending_o | output | 1 | Interrupt waiting, gated by inhibit |
| vector_o | output | 12 | Jump-table address of the source taken |

## Verification
A latch bit that is lost or set by mistake shows up at `pending_o` in the next cycle, as long as the inhibit is low. A wrong priority or a wrong remembered source appears at `vector_o` one cycle after the next address read. Such faults can stay hidden until the sequencer reads a vector again, so the bench alternates acknowledges and reads to expose them quickly. The comparison is made against a cycle-accurate model on every clock, which catches a clear that hits the wrong source within a few cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC    = 3;
    localparam int FIRST_NUM  = 3;
    localparam int SLOT_WORDS = 4;
    localparam int ADDR_W     = 12;
    localparam int IDX_W      = $clog2(NUM_SRC);

    typedef logic [NUM_SRC-1:0] src_mask_t;
    typedef logic [ADDR_W-1:0]  vec_addr_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } take_t;

    function automatic vec_addr_t slot_addr(vec_addr_t base, logic [IDX_W-1:0] idx);
        int off;
        off = (FIRST_NUM + int'(idx)) * SLOT_WORDS;
        return base + vec_addr_t'(off);
    endfunction

    function automatic src_mask_t idx_mask(take_t t);
        src_mask_t m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (t.valid && t.idx == IDX_W'(i)) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t set_i,
    input  src_mask_t clr_i,
    output src_mask_t held_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk) begin
            if (rst) cell_q <= 1'b0;
            else     cell_q <= (cell_q & ~clr_i[g]) | set_i[g];
        end
        assign held_o[g] = cell_q;
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |mask_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--)
            if (mask_i[i]) idx_o = IW'(i);
    end
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
    import irq_pkg::*;
#(
    parameter vec_addr_t VEC_BASE = 12'h010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_i,
    input  logic             ack_i,
    input  logic             found_i,
    input  logic [IDX_W-1:0] idx_i,
    output take_t            take_o,
    output vec_addr_t        vec_o
);
    take_t     take_q;
    vec_addr_t vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= '0;
            vec_q  <= '0;
        end else if (rd_i) begin
            take_q.valid <= found_i;
            take_q.idx   <= idx_i;
            if (found_i) vec_q <= slot_addr(VEC_BASE, idx_i);
        end else if (ack_i) begin
            take_q.valid <= 1'b0;
        end
    end

    assign take_o = take_q;
    assign vec_o  = vec_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_pkg::*;
#(
    parameter vec_addr_t VEC_BASE = 12'h010
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_req_i,
    input  logic                inhibit_i,
    input  logic                addr_rd_i,
    input  logic                svc_ack_i,
    output logic                pending_o,
    output logic [ADDR_W-1:0]   vector_o
);
    src_mask_t        held;
    src_mask_t        clr;
    src_mask_t        remain;
    take_t            take;
    logic             found;
    logic [IDX_W-1:0] pick;

    assign clr    = svc_ack_i ? idx_mask(take) : '0;
    assign remain = held & ~clr;

    irq_latch_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_req_i),
        .clr_i  (clr),
        .held_o (held)
    );

    irq_prio_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
        .mask_i  (remain),
        .found_o (found),
        .idx_o   (pick)
    );

    irq_vector_reg #(.VEC_BASE(VEC_BASE)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .rd_i    (addr_rd_i),
        .ack_i   (svc_ack_i),
        .found_i (found),
        .idx_i   (pick),
        .take_o  (take),
        .vec_o   (vector_o)
    );

    assign pending_o = (|held) & ~inhibit_i;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  irq_req_i,
    input logic        inhibit_i,
    input logic        addr_rd_i,
    input logic        svc_ack_i,
    input logic        pending_o,
    input logic [11:0] vector_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!pending_o && vector_o == 12'h000));

    a_r2_req_raises_pending: assert property (@(posedge clk) disable iff (rst)
        (|irq_req_i) |=> (pending_o || inhibit_i));

    a_r3_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |-> !pending_o);

    a_r4_vector_legal: assert property (@(posedge clk) disable iff (rst)
        addr_rd_i |=> ($stable(vector_o) || vector_o == 12'h01C
                       || vector_o == 12'h020 || vector_o == 12'h024));

    a_r10_vector_holds: assert property (@(posedge clk) disable iff (rst)
        !addr_rd_i |=> $stable(vector_o));

    a_r6_req_survives_ack: assert property (@(posedge clk) disable iff (rst)
        (svc_ack_i && (|irq_req_i)) |=> (pending_o || inhibit_i));
endmodule

bind irq_req_latch irq_req_latch_chk i_chk (.*);

// File: tb/test_irq_req_latch.sv
module test_irq_req_latch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  irq_req_i = '0;
    logic        inhibit_i = 1'b0;
    logic        addr_rd_i = 1'b0;
    logic        svc_ack_i = 1'b0;
    logic        pending_o;
    logic [11:0] vector_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model
    bit m_lat[3];
    bit m_tv;
    int m_ti;
    int m_vec;

    always #2 clk = ~clk;

    irq_req_latch i_irq_req_latch (
        .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .inhibit_i(inhibit_i),
        .addr_rd_i(addr_rd_i), .svc_ack_i(svc_ack_i),
        .pending_o(pending_o), .vector_o(vector_o)
    );

    task automatic model_edge(bit r, logic [2:0] q, bit rd, bit ack);
        int clr_i;
        int pick;
        if (r) begin
            foreach (m_lat[i]) m_lat[i] = 0;
            m_tv = 0; m_vec = 0;
            return;
        end
        clr_i = (ack && m_tv) ? m_ti : -1;
        pick = -1;
        for (int i = 2; i >= 0; i--)
            if (m_lat[i] && i != clr_i) pick = i;
        foreach (m_lat[i]) m_lat[i] = (m_lat[i] && i != clr_i) || q[i];
        if (rd) begin
            m_tv = (pick >= 0);
            if (pick >= 0) begin
                m_ti  = pick;
                m_vec = 16 + 4 * (pick + 3);
            end
        end else if (ack) begin
            m_tv = 0;
        end
    endtask

    task automatic compare(string tag);
        bit exp_p;
        exp_p = (m_lat[0] || m_lat[1] || m_lat[2]) && !inhibit_i;
        checks++;
        if (pending_o !== exp_p) begin
            errors++;
            $display("FAIL %s pending_o actual=%0b expected=%0b", tag, pending_o, exp_p);
        end
        checks++;
        if (vector_o !== 12'(m_vec)) begin
            errors++;
            $display("FAIL %s vector_o actual=0x%03h expected=0x%03h", tag, vector_o, m_vec);
        end
    endtask

    task automatic step(string tag, logic [2:0] q, bit inh, bit rd, bit ack);
        irq_req_i = q; inhibit_i = inh; addr_rd_i = rd; svc_ack_i = ack;
        @(posedge clk);
        model_edge(rst, q, rd, ack);
        @(negedge clk);
        irq_req_i = '0; addr_rd_i = 0; svc_ack_i = 0;
        compare(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ti = 0;
        @(negedge clk);
        step("R1", 3'b111, 0, 1, 1);
        step("R1", 3'b000, 0, 0, 0);
        rst = 0;
        step("R1", 3'b000, 0, 0, 0);
        step("R2", 3'b010, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R2", 3'b000, 0, 0, 0);
        step("R3", 3'b100, 1, 0, 0);
        step("R3", 3'b000, 1, 0, 0);
        step("R3", 3'b000, 0, 0, 0);
        step("R4", 3'b000, 0, 1, 0);   // picks 4 -> 0x020
        step("R4", 3'b001, 0, 0, 0);
        step("R4", 3'b000, 0, 1, 0);   // picks 3 -> 0x01C
        step("R5", 3'b000, 0, 0, 1);   // clears 3 only
        step("R7", 3'b000, 0, 0, 1);   // no effect
        step("R5", 3'b000, 0, 1, 0);   // picks 4
        step("R6", 3'b010, 0, 0, 1);   // 4 re-arrives with ack
        step("R6", 3'b000, 0, 1, 0);   // picks 4 again
        step("R5", 3'b000, 0, 0, 1);
        step("R4", 3'b000, 0, 1, 0);   // picks 5 -> 0x024
        step("R9", 3'b001, 0, 0, 0);
        step("R9", 3'b000, 0, 1, 1);   // clears 5, picks 3
        step("R9", 3'b000, 0, 0, 1);   // clears 3 -> empty
        step("R8", 3'b000, 0, 1, 0);   // nothing: vector holds
        step("R8", 3'b010, 0, 0, 0);
        step("R8", 3'b000, 0, 0, 1);   // clears nothing
        step("R10", 3'b000, 0, 0, 0);
        for (int k = 0; k < 400; k++) begin
            logic [2:0] q;
            q = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            step("R4 R5 R6 R9 R10", q, ($urandom % 5) == 0,
                 ($urandom % 4) == 0, ($urandom % 3) == 0);
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule